// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block tracks the power state of a DDR2-style memory device. The state follows the clock-enable pin and the bank status. On every clock edge it samples a registered copy of clock-enable together with three flags: all banks idle, some row open, and a self-refresh request. From these it picks one of four states: active, precharge power-down, active power-down or self-refresh. The kind of power-down depends on whether a row is open at the moment of entry.

Entry into and exit from power-down are decided on clock edges, and so is entry into self-refresh. Exit from self-refresh behaves differently. It follows a separate, unsampled copy of clock-enable, so the state drops back to active as soon as that pin rises, with no clock edge needed. Each state drives a mask that says which groups of input buffers stay powered. Two flags report protocol misuse: clock-enable dropped during a read or write, or a self-refresh request made while a bank was busy.

A tracker counts outstanding refresh obligations. It adds one for each elapsed average refresh interval, which is a parameterised cycle count equal to 7.8 µs at the device clock. It removes one for each refresh command. The tracker stops while the device refreshes itself and starts again from a clean slate after self-refresh ends.

Top module: `cke_pwr_ctrl`

## Requirements
- R1: While reset is held and on the first edge after it, the state is active (code 2'b00), the buffer mask is 4'b1111, both violation flags are low and the pending-refresh count is zero.
- R2: In active state, a clock edge that sees sampled clock-enable low, no row open, no access in progress and no self-refresh request moves the state to precharge power-down (code 2'b01).
- R3: In active state, a clock edge that sees sampled clock-enable low with a row open and no access in progress moves the state to active power-down (code 2'b10).
- R4: In active state, a clock edge that sees sampled clock-enable low, all banks idle, no row open, no access in progress and the self-refresh request high moves the state to self-refresh (code 2'b11).
- R5: A self-refresh request that meets the R4 conditions except bank idleness (banks not all idle, or a row open) is refused. The refusal flag is high for exactly the cycle after that edge, and the state takes the power-down of R2/R3 instead.
- R6: In either power-down state, an edge with sampled clock-enable high returns the state to active. An edge with it low keeps the current power-down. A self-refresh request in power-down has no effect.
- R7: Self-refresh ends as soon as the unsampled clock-enable input rises, before any clock edge. The sampled clock-enable input has no effect on the state while in self-refresh.
- R8: Buffer mask bit 0 = command/address/data inputs, bit 1 = clock, bit 2 = ODT, bit 3 = clock-enable. Active gives 4'b1111, either power-down gives 4'b1110 and self-refresh gives 4'b1000.
- R9: An edge that sees sampled clock-enable low while an access is in progress raises the access-violation flag for the next cycle. In active state it also blocks every power-down or self-refresh entry on that edge.
- R10: Outside self-refresh the pending-refresh count rises by one at the REFI_CYC-th edge after reset or reload, and every REFI_CYC edges after that. It falls by one on an edge with a refresh command, stays put when both happen together, and saturates at MAX_PEND, where the overdue flag is high.
- R11: During self-refresh the pending count and the interval timer hold, and refresh commands are ignored. On the first edge after self-refresh ends, the count clears to zero and the timer restarts a full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_sync | input | 1 | Clock-enable as registered on the clock |
| cke_async | input | 1 | Unsampled clock-enable, used to leave self-refresh |
| banks_idle | input | 1 | All banks precharged |
| row_active | input | 1 | At least one row open |
| sr_cmd | input | 1 | Self-refresh entry request with this edge |
| access_busy | input | 1 | Read or write burst in progress |
| refresh_cmd | input | 1 | Refresh command issued on this edge |
| pwr_state | output | 2 | Current power state code |
| buf_en | output | 4 | Input buffer enable mask |
| viol_access | output | 1 | Clock-enable dropped during an access |
| sr_refused | output | 1 | Self-refresh request refused |
| refresh_pending | output | $clog2(MAX_PEND+1) | Outstanding refresh obligations |
| refresh_overdue | output | 1 | Pending count at its ceiling |

## Verification
The bench builds the block with REFI_CYC = 20 and MAX_PEND = 3 instead of the full-rate interval. With these values, the first interval tick, the cancelling effect of a refresh command and saturation at the ceiling all appear within about a hundred cycles. A self-refresh stay of forty cycles covers two full intervals, so a frozen counter is told apart from a running one. The asynchronous exit is checked between clock edges.

// File: rtl/cke_pwr_pkg.sv
`timescale 1ns/1ps
package cke_pwr_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE   = 2'b00,
        PS_PRE_PD   = 2'b01,
        PS_ACT_PD   = 2'b10,
        PS_SELF_REF = 2'b11
    } pwr_state_e;

    typedef struct packed {
        logic cke;
        logic odt;
        logic clk;
        logic cmd;
    } buf_en_s;

    function automatic buf_en_s buf_mask(pwr_state_e s);
        buf_en_s m;
        m.cke = 1'b1;
        m.odt = (s != PS_SELF_REF);
        m.clk = (s != PS_SELF_REF);
        m.cmd = (s == PS_ACTIVE);
        return m;
    endfunction

endpackage

// File: rtl/cke_pd_fsm.sv
`timescale 1ns/1ps
module cke_pd_fsm
    import cke_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cke_sync,
    input  logic       banks_idle,
    input  logic       row_active,
    input  logic       sr_cmd,
    input  logic       access_busy,
    input  logic       sr_active,
    output pwr_state_e pd_state,
    output logic       sr_enter,
    output logic       viol_access,
    output logic       sr_refused
);
    pwr_state_e nxt;
    logic       may_drop;
    logic       sr_ok;
    logic       refuse_d;

    always_comb begin
        nxt      = pd_state;
        sr_enter = 1'b0;
        refuse_d = 1'b0;
        may_drop = !cke_sync && !access_busy && !sr_active;
        sr_ok    = banks_idle && !row_active;
        unique case (pd_state)
            PS_ACTIVE: begin
                if (may_drop) begin
                    if (sr_cmd && sr_ok) begin
                        sr_enter = 1'b1;
                    end else begin
                        refuse_d = sr_cmd;
                        nxt      = row_active ? PS_ACT_PD : PS_PRE_PD;
                    end
                end
            end
            PS_PRE_PD, PS_ACT_PD: begin
                if (cke_sync) nxt = PS_ACTIVE;
            end
            default: nxt = PS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_state    <= PS_ACTIVE;
            viol_access <= 1'b0;
            sr_refused  <= 1'b0;
        end else begin
            pd_state    <= nxt;
            viol_access <= access_busy && !cke_sync;
            sr_refused  <= refuse_d;
        end
    end
endmodule

// File: rtl/cke_sr_latch.sv
`timescale 1ns/1ps
module cke_sr_latch (
    input  logic clk,
    input  logic rst,
    input  logic cke_async,
    input  logic sr_enter,
    output logic sr_active
);
    always_ff @(posedge clk or posedge cke_async) begin
        if (cke_async) begin
            sr_active <= 1'b0;
        end else if (rst) begin
            sr_active <= 1'b0;
        end else if (sr_enter) begin
            sr_active <= 1'b1;
        end
    end
endmodule

// File: rtl/cke_refi_tracker.sv
`timescale 1ns/1ps
module cke_refi_tracker #(
    parameter int REFI_CYC = 1560,
    parameter int MAX_PEND = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              sr_active,
    input  logic                              refresh_cmd,
    output logic [$clog2(MAX_PEND+1)-1:0]     pending,
    output logic                              overdue
);
    localparam int TMR_W  = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
    localparam int PEND_W = $clog2(MAX_PEND + 1);
    localparam logic [TMR_W-1:0]  TMR_TOP  = TMR_W'(REFI_CYC - 1);
    localparam logic [PEND_W-1:0] PEND_TOP = PEND_W'(MAX_PEND);

    logic [TMR_W-1:0] timer;
    logic             sr_was;
    logic             tick;

    assign tick    = (timer == '0);
    assign overdue = (pending == PEND_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            timer   <= TMR_TOP;
            pending <= '0;
            sr_was  <= 1'b0;
        end else begin
            sr_was <= sr_active;
            if (sr_active) begin
                timer   <= timer;
                pending <= pending;
            end else if (sr_was) begin
                timer   <= TMR_TOP;
                pending <= '0;
            end else begin
                timer <= tick ? TMR_TOP : timer - 1'b1;
                if (tick && !refresh_cmd && pending != PEND_TOP) begin
                    pending <= pending + 1'b1;
                end else if (!tick && refresh_cmd && pending != '0) begin
                    pending <= pending - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cke_pwr_ctrl.sv
`timescale 1ns/1ps
module cke_pwr_ctrl
    import cke_pwr_pkg::*;
#(
    parameter int REFI_CYC = 1560,
    parameter int MAX_PEND = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cke_sync,
    input  logic                          cke_async,
    input  logic                          banks_idle,
    input  logic                          row_active,
    input  logic                          sr_cmd,
    input  logic                          access_busy,
    input  logic                          refresh_cmd,
    output logic [1:0]                    pwr_state,
    output logic [3:0]                    buf_en,
    output logic                          viol_access,
    output logic                          sr_refused,
    output logic [$clog2(MAX_PEND+1)-1:0] refresh_pending,
    output logic                          refresh_overdue
);
    pwr_state_e pd_state;
    pwr_state_e cur;
    logic       sr_enter;
    logic       sr_active;

    cke_pd_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cke_sync    (cke_sync),
        .banks_idle  (banks_idle),
        .row_active  (row_active),
        .sr_cmd      (sr_cmd),
        .access_busy (access_busy),
        .sr_active   (sr_active),
        .pd_state    (pd_state),
        .sr_enter    (sr_enter),
        .viol_access (viol_access),
        .sr_refused  (sr_refused)
    );

    cke_sr_latch u_sr (
        .clk       (clk),
        .rst       (rst),
        .cke_async (cke_async),
        .sr_enter  (sr_enter),
        .sr_active (sr_active)
    );

    cke_refi_tracker #(
        .REFI_CYC (REFI_CYC),
        .MAX_PEND (MAX_PEND)
    ) u_refi (
        .clk         (clk),
        .rst         (rst),
        .sr_active   (sr_active),
        .refresh_cmd (refresh_cmd),
        .pending     (refresh_pending),
        .overdue     (refresh_overdue)
    );

    assign cur       = sr_active ? PS_SELF_REF : pd_state;
    assign pwr_state = cur;
    assign buf_en    = buf_mask(cur);
endmodule

// File: rtl/cke_pwr_chk.sv
`timescale 1ns/1ps
module cke_pwr_chk #(
    parameter int MAX_PEND = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          cke_sync,
    input logic                          banks_idle,
    input logic                          access_busy,
    input logic [1:0]                    pwr_state,
    input logic [3:0]                    buf_en,
    input logic                          viol_access,
    input logic                          sr_refused,
    input logic [$clog2(MAX_PEND+1)-1:0] refresh_pending
);
    AST_SR_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pwr_state == 2'b11 && $past(pwr_state) != 2'b11) |-> $past(banks_idle)); // R4

    AST_PD_EXIT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(pwr_state) == 2'b01 || $past(pwr_state) == 2'b10) && $past(cke_sync))
        |-> pwr_state == 2'b00); // R6

    AST_ACCESS_VIOL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(access_busy && !cke_sync)) |-> viol_access); // R9

    AST_SR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pwr_state == 2'b11 && $past(pwr_state) == 2'b11) |-> $stable(refresh_pending)); // R11

    AST_SR_BUFFERS: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 2'b11 |-> buf_en == 4'b1000); // R8

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
        refresh_pending <= ($clog2(MAX_PEND+1))'(MAX_PEND)); // R10

    AST_REFUSE_NO_SR: assert property (@(posedge clk) disable iff (rst)
        sr_refused |-> pwr_state != 2'b11); // R5
endmodule

bind cke_pwr_ctrl cke_pwr_chk #(.MAX_PEND(MAX_PEND)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cke_sync        (cke_sync),
    .banks_idle      (banks_idle),
    .access_busy     (access_busy),
    .pwr_state       (pwr_state),
    .buf_en          (buf_en),
    .viol_access     (viol_access),
    .sr_refused      (sr_refused),
    .refresh_pending (refresh_pending)
);

// File: tb/cke_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module cke_pwr_ctrl_bench;
    localparam int REFI = 20;
    localparam int MAXP = 3;
    localparam int PW   = $clog2(MAXP + 1);
    localparam int NVEC = 14;

    // {cke, idle, row, sr, busy, exp_state[1:0], exp_viol, exp_refused}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b110000000,  // stay active (R6)
        9'b010000100,  // precharge power-down (R2)
        9'b010000100,  // hold power-down (R6)
        9'b110000000,  // exit (R6)
        9'b001001000,  // active power-down (R3)
        9'b001101000,  // request ignored in power-down (R6)
        9'b101000000,  // exit (R6)
        9'b001010010,  // drop during access (R9)
        9'b101010000,  // flag clears (R9)
        9'b001101001,  // refused request (R5)
        9'b101000000,  // exit, refusal clears (R5)
        9'b010110010,  // request during access blocked (R9)
        9'b010101100,  // self-refresh entry (R4)
        9'b010001100   // stays in self-refresh (R7)
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke_sync = 1'b1;
    logic          cke_async = 1'b1;
    logic          banks_idle = 1'b1;
    logic          row_active = 1'b0;
    logic          sr_cmd = 1'b0;
    logic          access_busy = 1'b0;
    logic          refresh_cmd = 1'b0;
    logic [1:0]    pwr_state;
    logic [3:0]    buf_en;
    logic          viol_access;
    logic          sr_refused;
    logic [PW-1:0] refresh_pending;
    logic          refresh_overdue;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cke_pwr_ctrl #(.REFI_CYC(REFI), .MAX_PEND(MAXP)) u_cke_pwr_ctrl (
        .clk             (clk),
        .rst             (rst),
        .cke_sync        (cke_sync),
        .cke_async       (cke_async),
        .banks_idle      (banks_idle),
        .row_active      (row_active),
        .sr_cmd          (sr_cmd),
        .access_busy     (access_busy),
        .refresh_cmd     (refresh_cmd),
        .pwr_state       (pwr_state),
        .buf_en          (buf_en),
        .viol_access     (viol_access),
        .sr_refused      (sr_refused),
        .refresh_pending (refresh_pending),
        .refresh_overdue (refresh_overdue)
    );

    function automatic logic [3:0] exp_mask(logic [1:0] s);
        case (s)
            2'b00:   return 4'b1111;
            2'b11:   return 4'b1000;
            default: return 4'b1110;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cke_sync = 1'b1; cke_async = 1'b1;
        banks_idle = 1'b1; row_active = 1'b0;
        sr_cmd = 1'b0; access_busy = 1'b0; refresh_cmd = 1'b0;
        step();
        step();
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 state", pwr_state, 2'b00);
        chk("R1 mask", buf_en, 4'b1111);
        chk("R1 flags", {viol_access, sr_refused}, 2'b00);
        chk("R1 pending", refresh_pending, 0);
        step();
        chk("R1 state after edge", pwr_state, 2'b00);

        // table walk: R2 R3 R4 R5 R6 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            cke_sync    = VEC[i][8];
            cke_async   = VEC[i][8];
            banks_idle  = VEC[i][7];
            row_active  = VEC[i][6];
            sr_cmd      = VEC[i][5];
            access_busy = VEC[i][4];
            step();
            chk($sformatf("R2/R3/R4/R6 state row %0d", i), pwr_state, VEC[i][3:2]);
            chk($sformatf("R8 mask row %0d", i), buf_en, exp_mask(VEC[i][3:2]));
            chk($sformatf("R9 viol row %0d", i), viol_access, VEC[i][1]);
            chk($sformatf("R5 refused row %0d", i), sr_refused, VEC[i][0]);
        end

        // R7: sampled clock-enable ignored in self-refresh
        cke_sync = 1'b1;
        step();
        chk("R7 sampled cke ignored", pwr_state, 2'b11);
        // R7: asynchronous exit between edges
        cke_async = 1'b1;
        #1;
        chk("R7 async exit state", pwr_state, 2'b00);
        chk("R8 async exit mask", buf_en, 4'b1111);

        // R10/R11: freeze with non-zero pending
        do_reset();
        repeat (25) step();
        chk("R10 first tick", refresh_pending, 1);
        cke_sync = 1'b0; cke_async = 1'b0; sr_cmd = 1'b1;
        step();
        chk("R4 entry", pwr_state, 2'b11);
        sr_cmd = 1'b0;
        repeat (40) step();
        chk("R11 frozen count", refresh_pending, 1);
        refresh_cmd = 1'b1;
        step();
        refresh_cmd = 1'b0;
        chk("R11 refresh ignored", refresh_pending, 1);
        cke_async = 1'b1; cke_sync = 1'b1;
        #1;
        chk("R7 exit", pwr_state, 2'b00);
        step();
        chk("R11 reload clears", refresh_pending, 0);
        repeat (REFI - 1) step();
        chk("R11 full interval pending", refresh_pending, 0);
        step();
        chk("R11 tick after full interval", refresh_pending, 1);

        // R10: counting, cancel, saturation
        do_reset();
        repeat (REFI - 1) step();
        chk("R10 before tick", refresh_pending, 0);
        step();
        chk("R10 tick", refresh_pending, 1);
        refresh_cmd = 1'b1;
        step();
        refresh_cmd = 1'b0;
        chk("R10 refresh decrements", refresh_pending, 0);
        repeat (79) step();
        chk("R10 saturated", refresh_pending, MAXP);
        chk("R10 overdue", refresh_overdue, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule